// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block sits at the front of the external bus path. It looks at the 24-bit address of each memory cycle when the cycle strobe is high and first settles where the access goes. A fixed 4 KB special region at the top of the map can be served from on-chip memory, and a live routing input picks internal or external for that region on every access. Every other address goes to the external bus.

For an external cycle, the block drops the top four address bits to form a 20-bit bus address. It compares that address against six programmable windows, each held as a base, a mask and an enable, and pulls low the active-low select of the lowest-numbered window that hits. It also reports a bus-configuration index for the later bus logic. That index names the asserted select. When no window hits, it names the last select.

All outputs are registered, so they show the decode one clock after the cycle is presented. When no cycle is presented, the outputs go back to their idle values.

Top module: `ext_cs_decode`

## Requirements
- R1: During and right after reset, all six selects are high, `ext_cyc` is 0 and `bus_cfg` is 5. Window 0 holds base F2000h, mask FFF00h and is enabled. Windows 1 to 5 hold base 0 and mask 0 and are disabled.
- R2: A clock edge with `cyc_valid` low leaves all selects high, `ext_cyc` at 0 and `bus_cfg` at 5 after that edge.
- R3: A cycle to FF2000h–FF2FFFh with `ext_route_n` high is internal: no select asserts, `ext_cyc` is 0 and `bus_cfg` is 5.
- R4: A cycle to FF2000h–FF2FFFh with `ext_route_n` low is external and is decoded against the windows. After reset, FF2000h–FF20FFh asserts select 0.
- R5: For any address outside FF2000h–FF2FFFh, `ext_route_n` has no effect, and the cycle is external.
- R6: `ext_route_n` is not latched. Its value at the clock edge of each cycle decides that cycle, even on back-to-back cycles.
- R7: The bus address is `cyc_addr[19:0]`. Window k hits when it is enabled and (bus address & mask) equals (base & mask).
- R8: When several windows hit, only the lowest-numbered one asserts its select, and `bus_cfg` equals its number.
- R9: An external cycle that hits no window asserts no select, sets `ext_cyc` to 1 and sets `bus_cfg` to 5.
- R10: Selects, `ext_cyc` and `bus_cfg` change one clock after the cycle is sampled. At most one select is low at any time.
- R11: Configuration writes use `cfg_sel` codes 0 = base, 1 = mask and 2 = enable (`cfg_wdata[0]`). A write with code 3, or with `cfg_idx` 6 or 7, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A memory cycle is presented this clock |
| cyc_addr | input | 24 | Internal address of the cycle |
| ext_route_n | input | 1 | Low sends the special region to the external bus; high keeps it internal |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 3 | Window number to write |
| cfg_sel | input | 2 | Field to write: 0 base, 1 mask, 2 enable |
| cfg_wdata | input | 20 | Write data |
| cs_n | output | 6 | Active-low chip selects, bit k for window k |
| ext_cyc | output | 1 | The registered cycle goes to the external bus |
| bus_cfg | output | 3 | Bus-configuration index for the cycle |

## Verification
The address patterns are picked so that each result has a different cause. Addresses at the ends of the special region are sent with both levels of the routing input, which separates internal cycles from external ones. An address that differs from a special-region address only in its top nibble shows that the routing input is ignored outside the region and that the bus address is truncated. Addresses where two windows overlap, where a window is disabled and where no window covers the address separate the priority rule, the enable bit and the fallback to configuration 5. Back-to-back cycles that flip only the routing input, writes to invalid indices and fields, and a second reset check that the routing input is not latched, that ignored writes change nothing and that the reset mapping comes back.

// File: rtl/ext_cs_decode.sv
module ext_cs_decode #(
  parameter int ADDR_W    = 24,
  parameter int BUS_W     = 20,
  parameter int NUM_CS    = 6,
  parameter logic [ADDR_W-1:0] SPEC_BASE = 24'hFF2000,
  parameter logic [ADDR_W-1:0] SPEC_MASK = 24'hFFF000,
  parameter logic [BUS_W-1:0]  CS0_BASE  = 20'hF2000,
  parameter logic [BUS_W-1:0]  CS0_MASK  = 20'hFFF00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_valid,
  input  logic [ADDR_W-1:0]         cyc_addr,
  input  logic                      ext_route_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_idx,
  input  logic [1:0]                cfg_sel,
  input  logic [BUS_W-1:0]          cfg_wdata,
  output logic [NUM_CS-1:0]         cs_n,
  output logic                      ext_cyc,
  output logic [$clog2(NUM_CS)-1:0] bus_cfg
);
  localparam int IDX_W = $clog2(NUM_CS);
  localparam logic [IDX_W-1:0] DFLT = IDX_W'(NUM_CS - 1);

  logic [BUS_W-1:0]  base_q [NUM_CS];
  logic [BUS_W-1:0]  mask_q [NUM_CS];
  logic [NUM_CS-1:0] en_q;
  logic [NUM_CS-1:0] hit;
  logic [NUM_CS-1:0] win;
  logic [IDX_W-1:0]  win_idx;

  wire [BUS_W-1:0] bus_addr = cyc_addr[BUS_W-1:0];
  wire in_spec  = (cyc_addr & SPEC_MASK) == (SPEC_BASE & SPEC_MASK);
  wire is_ext   = !(in_spec && ext_route_n);

  for (genvar k = 0; k < NUM_CS; k++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[k] <= (k == 0) ? CS0_BASE : '0;
        mask_q[k] <= (k == 0) ? CS0_MASK : '0;
        en_q[k]   <= (k == 0);
      end else if (cfg_we && cfg_idx == IDX_W'(k)) begin
        case (cfg_sel)
          2'd0: base_q[k] <= cfg_wdata;
          2'd1: mask_q[k] <= cfg_wdata;
          2'd2: en_q[k]   <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
    assign hit[k] = en_q[k] && ((bus_addr & mask_q[k]) == (base_q[k] & mask_q[k]));
  end

  always_comb begin
    win     = '0;
    win_idx = DFLT;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (hit[k]) begin
        win     = NUM_CS'(1) << k;
        win_idx = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= '1;
      ext_cyc <= 1'b0;
      bus_cfg <= DFLT;
    end else if (cyc_valid && is_ext) begin
      cs_n    <= ~win;
      ext_cyc <= 1'b1;
      bus_cfg <= win_idx;
    end else begin
      cs_n    <= '1;
      ext_cyc <= 1'b0;
      bus_cfg <= DFLT;
    end
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> (&cs_n && !ext_cyc && bus_cfg == DFLT));

  a_r3_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && in_spec && ext_route_n) |=> (&cs_n && !ext_cyc));

  a_r9_default_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> bus_cfg == DFLT);

  a_r8_cfg_names_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> ((~cs_n) == (NUM_CS'(1) << bus_cfg)));

  a_r10_select_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> ext_cyc);
endmodule

// File: tb/ext_cs_decode_tb.sv
module ext_cs_decode_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic        ext_route_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic [5:0]  cs_n;
  logic        ext_cyc;
  logic [2:0]  bus_cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_cs_decode u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .ext_route_n(ext_route_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cs_n(cs_n), .ext_cyc(ext_cyc), .bus_cfg(bus_cfg)
  );

  // {addr, route_n, exp cs_n, exp ext, exp cfg}
  localparam logic [34:0] VEC [13] = '{
    {24'hFF2000, 1'b1, 6'h3F, 1'b0, 3'd5},  // R3 internal
    {24'hFF2000, 1'b0, 6'h3E, 1'b1, 3'd0},  // R4 CS0
    {24'hFF20FF, 1'b0, 6'h3E, 1'b1, 3'd0},  // R4 top of CS0
    {24'hFF2100, 1'b0, 6'h1F, 1'b1, 3'd5},  // R4 special, CS5 window
    {24'hFF2FFF, 1'b1, 6'h3F, 1'b0, 3'd5},  // R3 region end
    {24'hFF3000, 1'b1, 6'h1F, 1'b1, 3'd5},  // R5 outside region
    {24'h0F2000, 1'b1, 6'h3E, 1'b1, 3'd0},  // R5 R7 truncation
    {24'h010500, 1'b1, 6'h3D, 1'b1, 3'd1},  // R8 overlap 1 and 2
    {24'h011000, 1'b0, 6'h3D, 1'b1, 3'd1},  // R7 CS1 only
    {24'h450000, 1'b1, 6'h37, 1'b1, 3'd3},  // R7 CS3
    {24'h020000, 1'b0, 6'h3F, 1'b1, 3'd5},  // R9 CS4 disabled
    {24'h07FFFF, 1'b1, 6'h37, 1'b1, 3'd3},  // R7 CS3 top
    {24'h0FFFFF, 1'b0, 6'h1F, 1'b1, 3'd5}   // R7 CS5
  };

  task automatic check(string req, logic [5:0] ecs, logic eext, logic [2:0] ecfg);
    checks++;
    if (cs_n !== ecs || ext_cyc !== eext || bus_cfg !== ecfg) begin
      fails++;
      $display("FAIL %s: got cs_n=%h ext=%b cfg=%0d, expected cs_n=%h ext=%b cfg=%0d",
               req, cs_n, ext_cyc, bus_cfg, ecs, eext, ecfg);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [1:0] sel, logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(logic [23:0] a, logic r, string req,
                     logic [5:0] ecs, logic eext, logic [2:0] ecfg);
    cyc_valid = 1'b1; cyc_addr = a; ext_route_n = r;
    @(negedge clk);
    check(req, ecs, eext, ecfg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 6'h3F, 1'b0, 3'd5);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 6'h3F, 1'b0, 3'd5);
    cyc(24'hFF2000, 1'b0, "R1 reset map", 6'h3E, 1'b1, 3'd0);
    cyc_valid = 1'b0;
    wr(3'd1, 2'd0, 20'h10000); wr(3'd1, 2'd1, 20'hF0000); wr(3'd1, 2'd2, 20'h1);
    wr(3'd2, 2'd0, 20'h10000); wr(3'd2, 2'd1, 20'hFF000); wr(3'd2, 2'd2, 20'h1);
    wr(3'd3, 2'd0, 20'h40000); wr(3'd3, 2'd1, 20'hC0000); wr(3'd3, 2'd2, 20'h1);
    wr(3'd4, 2'd0, 20'h20000); wr(3'd4, 2'd1, 20'hFF000);
    wr(3'd5, 2'd0, 20'h80000); wr(3'd5, 2'd1, 20'h80000); wr(3'd5, 2'd2, 20'h1);
    for (int i = 0; i < 13; i++) begin
      cyc(VEC[i][34:11], VEC[i][10], $sformatf("vector %0d", i),
          VEC[i][9:4], VEC[i][3], VEC[i][2:0]);
    end
    // R2 idle
    cyc_valid = 1'b0;
    @(negedge clk);
    check("R2", 6'h3F, 1'b0, 3'd5);
    // R6 back-to-back, only route changes
    cyc(24'hFF2010, 1'b1, "R6 high", 6'h3F, 1'b0, 3'd5);
    cyc(24'hFF2010, 1'b0, "R6 low", 6'h3E, 1'b1, 3'd0);
    cyc(24'hFF2010, 1'b1, "R6 high again", 6'h3F, 1'b0, 3'd5);
    cyc_valid = 1'b0;
    // R11 enable CS4, then ignored writes
    wr(3'd4, 2'd2, 20'h1);
    cyc(24'h020ABC, 1'b1, "R11 enable", 6'h2F, 1'b1, 3'd4);
    cyc_valid = 1'b0;
    wr(3'd4, 2'd3, 20'h0);
    wr(3'd6, 2'd2, 20'h0);
    wr(3'd7, 2'd1, 20'h0);
    cyc(24'h020000, 1'b0, "R11 ignored writes", 6'h2F, 1'b1, 3'd4);
    cyc_valid = 1'b0;
    // R8 disable CS0, CS5 now serves special region
    wr(3'd0, 2'd2, 20'h0);
    cyc(24'hFF2000, 1'b0, "R8 CS0 off", 6'h1F, 1'b1, 3'd5);
    cyc_valid = 1'b0;
    // R1 second reset restores map
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(24'hFF2000, 1'b0, "R1 re-reset CS0", 6'h3E, 1'b1, 3'd0);
    cyc(24'h020000, 1'b0, "R1 re-reset CS4 off", 6'h3F, 1'b1, 3'd5);
    cyc_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: got timeout, expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule